// File: doc/BRIEF.md
# Dual-Input Long-Press Reset Generator

This block turns a deliberate two-button press into a system reset. It watches two active-low manual-reset inputs. When both are held low together for a selectable hold time, it drives one active-low reset pulse of fixed width. The inputs are assumed to be already synchronized and debounced. The output is modelled as an open-drain driver. `rst_pull` is the enable that pulls the shared line low. `rst_line_n` is the line level that results when the only other driver is an external pull-up. When idle, the driver is released, so other open-drain sources can share the line.

A 3-bit select picks one of eight hold times, and a 1-bit variant select picks the pulse width. For production test, the long hold can be bypassed. The tester holds the first input low and clocks the second input eight times, after which the pulse fires after a short fixed delay. All timing values are cycle counts. By default they are derived from the clock frequency, and they can be overridden for scaled-down simulation.

Top module: `dual_press_reset_gen`

## Requirements
- R1: The hold count advances only on clock edges where `mr1_n` and `mr2_n` are both sampled low. `rst_pull` rises at the H-th consecutive such edge, where H is the selected hold length.
- R2: `hold_sel` values 0..7 give H = HALF_SEC_CYC times 1, 2, 3, 4, 5, 6, 8 and 10 respectively (0.5 s to 5 s nominal).
- R3: Any edge where either input is sampled high clears the hold count. A later press then needs a full H consecutive low edges.
- R4: A pulse keeps `rst_pull` high for exactly PULSE_SHORT_CYC cycles (nominal 2.2 ms) when `long_pulse` is 0 at the firing edge, and for PULSE_LONG_CYC cycles (nominal 70 ms) when it is 1.
- R5: `rst_pull` is 1 only during a pulse. `rst_line_n` is always its inverse, so the line is released (high) when idle.
- R6: After a pulse, no new hold count starts until at least one input has been sampled high. Inputs held low produce exactly one pulse.
- R7: Test entry counts rising edges of `mr2_n` while `mr1_n` stays low. A rising edge counts only once `mr1_n` has been sampled low on TEST_SETUP_CYC earlier edges. Earlier rising edges are ignored.
- R8: On the 8th counted rising edge, test mode begins. `rst_pull` rises TEST_DELAY_CYC edges later, whatever `hold_sel` is.
- R9: Releasing `mr1_n` before the 8th counted edge, or during the test delay, aborts entry and clears the edge count.
- R10: Synchronous active-high `rst` releases the output and clears the hold timer, the pulse and the test-mode state. After `rst` falls, a press still held low needs a full H edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mr1_n | input | 1 | Manual reset input 1, active low |
| mr2_n | input | 1 | Manual reset input 2, active low; also the test clock |
| hold_sel | input | 3 | Hold time select |
| long_pulse | input | 1 | Pulse width variant: 0 short, 1 long |
| rst_pull | output | 1 | Open-drain pull-down enable, 1 while the pulse is active |
| rst_line_n | output | 1 | Resulting reset line level, active low |

## Verification
Inputs are changed just after a rising edge, so the next edge is the first to sample them. The output register then sets on that same edge in which the condition completes. The pulse rises on the H-th low edge of a press, or TEST_DELAY_CYC edges after the edge that saw the 8th counted MR2 rise. It falls PULSE cycles after it rises. The bench steps edge by edge and samples two time units after each edge. For every result it checks the last edge before the expected change as well as the edge of the change, so a result that comes one cycle early or late is caught. It sweeps all eight hold selects with both pulse widths at reduced cycle counts.

// File: rtl/dprg_pkg.sv
package dprg_pkg;

  typedef enum logic [1:0] {
    TE_IDLE,
    TE_COUNT,
    TE_DELAY,
    TE_DONE
  } te_state_e;

  // hold length in half-second units
  function automatic int unsigned hold_mult(input logic [2:0] sel);
    case (sel)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      3'd4: return 5;
      3'd5: return 6;
      3'd6: return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/dprg_hold_timer.sv
module dprg_hold_timer #(
  parameter int unsigned HALF_SEC_CYC = 20,
  localparam int unsigned HW = $clog2(10 * HALF_SEC_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       both_low,
  input  logic [2:0] hold_sel,
  input  logic       busy,
  input  logic       fire_any,
  output logic       hold_fire
);
  import dprg_pkg::*;

  logic [HW-1:0] cnt;
  logic [HW-1:0] target;
  logic          armed;

  always_comb begin
    target    = HW'(HALF_SEC_CYC * hold_mult(hold_sel));
    hold_fire = armed && both_low && !busy && (cnt == target - HW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (fire_any) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!both_low) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (armed && !busy) begin
      cnt <= cnt + HW'(1);
    end else begin
      cnt <= '0;
    end
  end

  p_release_clears_r3: assert property (@(posedge clk) disable iff (rst)
    !both_low |=> cnt == '0);

  p_no_repeat_r6: assert property (@(posedge clk) disable iff (rst)
    (!armed && both_low) |=> cnt == '0);

endmodule

// File: rtl/dprg_pulse_gen.sv
module dprg_pulse_gen #(
  parameter int unsigned PULSE_SHORT_CYC = 5,
  parameter int unsigned PULSE_LONG_CYC  = 12,
  localparam int unsigned PMAX = (PULSE_LONG_CYC > PULSE_SHORT_CYC) ? PULSE_LONG_CYC : PULSE_SHORT_CYC,
  localparam int unsigned PW   = $clog2(PMAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic long_sel,
  output logic active
);
  logic [PW-1:0] pcnt;
  logic [PW-1:0] len_q;
  logic [PW-1:0] plen;

  always_comb plen = long_sel ? PW'(PULSE_LONG_CYC) : PW'(PULSE_SHORT_CYC);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pcnt   <= '0;
      len_q  <= '0;
    end else if (!active) begin
      if (fire) begin
        active <= 1'b1;
        pcnt   <= '0;
        len_q  <= plen;
      end
    end else if (pcnt == len_q - PW'(1)) begin
      active <= 1'b0;
      pcnt   <= '0;
    end else begin
      pcnt <= pcnt + PW'(1);
    end
  end

  p_start_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && !active) |=> active);

  p_len_bound_r4: assert property (@(posedge clk) disable iff (rst)
    active |-> pcnt < len_q);

endmodule

// File: rtl/dprg_test_entry.sv
module dprg_test_entry #(
  parameter int unsigned TEST_SETUP_CYC = 4,
  parameter int unsigned TEST_DELAY_CYC = 9,
  parameter int unsigned ENTRY_EDGES    = 8,
  localparam int unsigned SW = $clog2(TEST_SETUP_CYC + 1),
  localparam int unsigned DW = $clog2(TEST_DELAY_CYC + 1),
  localparam int unsigned EW = $clog2(ENTRY_EDGES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic mr1_low,
  input  logic mr2_rise,
  input  logic busy,
  input  logic fire_any,
  output logic test_fire
);
  import dprg_pkg::*;

  te_state_e     state;
  logic [SW-1:0] win;
  logic [EW-1:0] ecnt;
  logic [DW-1:0] dcnt;
  logic          win_open;

  always_comb begin
    win_open  = (win == SW'(TEST_SETUP_CYC));
    test_fire = (state == TE_DELAY) && mr1_low && !busy &&
                (dcnt == DW'(TEST_DELAY_CYC - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || !mr1_low) begin
      state <= TE_IDLE;
      win   <= '0;
      ecnt  <= '0;
      dcnt  <= '0;
    end else begin
      if (!win_open) win <= win + SW'(1);
      case (state)
        TE_IDLE: state <= TE_COUNT;
        TE_COUNT: begin
          if (fire_any) begin
            state <= TE_DONE;
            ecnt  <= '0;
          end else if (mr2_rise && win_open) begin
            if (ecnt == EW'(ENTRY_EDGES - 1)) begin
              state <= TE_DELAY;
              ecnt  <= '0;
              dcnt  <= '0;
            end else begin
              ecnt <= ecnt + EW'(1);
            end
          end
        end
        TE_DELAY: begin
          if (fire_any || busy) state <= TE_DONE;
          else                  dcnt  <= dcnt + DW'(1);
        end
        default: state <= TE_DONE;
      endcase
    end
  end

  p_abort_r9: assert property (@(posedge clk) disable iff (rst)
    !mr1_low |=> (state == TE_IDLE) && (ecnt == '0));

  p_window_r7: assert property (@(posedge clk) disable iff (rst)
    (mr1_low && mr2_rise && !win_open) |=> $stable(ecnt));

  p_fire_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (test_fire && mr1_low) |=> state == TE_DONE);

endmodule

// File: rtl/dual_press_reset_gen.sv
module dual_press_reset_gen #(
  parameter int unsigned CLK_HZ          = 8_000_000,
  parameter int unsigned HALF_SEC_CYC    = CLK_HZ / 2,
  parameter int unsigned PULSE_SHORT_CYC = CLK_HZ / 5000 * 11,
  parameter int unsigned PULSE_LONG_CYC  = CLK_HZ / 100 * 7,
  parameter int unsigned TEST_DELAY_CYC  = CLK_HZ / 4,
  parameter int unsigned TEST_SETUP_CYC  = CLK_HZ / 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mr1_n,
  input  logic       mr2_n,
  input  logic [2:0] hold_sel,
  input  logic       long_pulse,
  output logic       rst_pull,
  output logic       rst_line_n
);
  localparam int unsigned ENTRY_EDGES = 8;

  logic mr2_q;
  logic mr2_rise;
  logic both_low;
  logic hold_fire;
  logic test_fire;
  logic fire_any;
  logic active;

  always_ff @(posedge clk) begin
    if (rst) mr2_q <= 1'b1;
    else     mr2_q <= mr2_n;
  end

  always_comb begin
    mr2_rise   = mr2_n && !mr2_q;
    both_low   = !mr1_n && !mr2_n;
    fire_any   = hold_fire || test_fire;
    rst_pull   = active;
    rst_line_n = !active;
  end

  dprg_hold_timer #(
    .HALF_SEC_CYC(HALF_SEC_CYC)
  ) u_hold (
    .clk      (clk),
    .rst      (rst),
    .both_low (both_low),
    .hold_sel (hold_sel),
    .busy     (active),
    .fire_any (fire_any),
    .hold_fire(hold_fire)
  );

  dprg_test_entry #(
    .TEST_SETUP_CYC(TEST_SETUP_CYC),
    .TEST_DELAY_CYC(TEST_DELAY_CYC),
    .ENTRY_EDGES   (ENTRY_EDGES)
  ) u_test (
    .clk      (clk),
    .rst      (rst),
    .mr1_low  (!mr1_n),
    .mr2_rise (mr2_rise),
    .busy     (active),
    .fire_any (fire_any),
    .test_fire(test_fire)
  );

  dprg_pulse_gen #(
    .PULSE_SHORT_CYC(PULSE_SHORT_CYC),
    .PULSE_LONG_CYC (PULSE_LONG_CYC)
  ) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire_any),
    .long_sel(long_pulse),
    .active  (active)
  );

  p_sysrst_r10: assert property (@(posedge clk)
    rst |=> !rst_pull);

  p_pull_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pull) |-> $past(fire_any));

endmodule

// File: tb/dual_press_reset_gen_tb.sv
module dual_press_reset_gen_tb;
  localparam int HALF  = 20;
  localparam int SHORT = 5;
  localparam int LONG  = 12;
  localparam int DELAY = 9;
  localparam int SETUP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mr1_n = 1'b1;
  logic mr2_n = 1'b1;
  logic [2:0] hold_sel = 3'd0;
  logic long_pulse = 1'b0;
  logic rst_pull;
  logic rst_line_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_press_reset_gen #(
    .CLK_HZ(100), .HALF_SEC_CYC(HALF), .PULSE_SHORT_CYC(SHORT),
    .PULSE_LONG_CYC(LONG), .TEST_DELAY_CYC(DELAY), .TEST_SETUP_CYC(SETUP)
  ) u_dut (
    .clk(clk), .rst(rst), .mr1_n(mr1_n), .mr2_n(mr2_n),
    .hold_sel(hold_sel), .long_pulse(long_pulse),
    .rst_pull(rst_pull), .rst_line_n(rst_line_n)
  );

  function automatic int mult(input int s);
    case (s)
      6: return 8;
      7: return 10;
      default: return s + 1;
    endcase
  endfunction

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic mr2_clock();
    mr2_n = 1'b0; step();
    mr2_n = 1'b1; step();
  endtask

  task automatic idle(input int n);
    mr1_n = 1'b1; mr2_n = 1'b1; step(n);
  endtask

  initial begin
    step(3);
    chk("R10", "pull in reset", rst_pull, 1'b0);
    chk("R5", "line in reset", rst_line_n, 1'b1);
    rst = 1'b0;
    step(2);

    // R1 R2 R4 R5 R6: sweep every hold select with both widths
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 2; v++) begin
        int h;
        int p;
        h = HALF * mult(s);
        p = (v != 0) ? LONG : SHORT;
        hold_sel = 3'(s); long_pulse = 1'(v);
        mr1_n = 1'b0; mr2_n = 1'b0;
        step(h - 1);
        chk("R2", "edge before hold end", rst_pull, 1'b0);
        step();
        chk("R1", "pull at hold end", rst_pull, 1'b1);
        chk("R5", "line during pulse", rst_line_n, 1'b0);
        step(p - 1);
        chk("R4", "last pulse cycle", rst_pull, 1'b1);
        step();
        chk("R4", "pulse ended", rst_pull, 1'b0);
        chk("R5", "line released", rst_line_n, 1'b1);
        step(h + 3);
        chk("R6", "no repeat while held", rst_pull, 1'b0);
        idle(2);
      end
    end

    // R3: early release on each input restarts the count
    hold_sel = 3'd0; long_pulse = 1'b0;
    for (int w = 0; w < 2; w++) begin
      mr1_n = 1'b0; mr2_n = 1'b0;
      step(HALF - 1);
      chk("R3", "before release", rst_pull, 1'b0);
      if (w == 0) mr1_n = 1'b1; else mr2_n = 1'b1;
      step();
      mr1_n = 1'b0; mr2_n = 1'b0;
      step(HALF - 1);
      chk("R3", "no pulse on carried count", rst_pull, 1'b0);
      step();
      chk("R3", "pulse after fresh count", rst_pull, 1'b1);
      step(SHORT + 1);
      idle(2);
    end

    // R7 R8: early MR2 edges ignored, then eight counted edges
    hold_sel = 3'd7;
    mr1_n = 1'b0;
    mr2_clock();
    mr2_clock();
    for (int k = 0; k < 7; k++) mr2_clock();
    step(DELAY + 2);
    chk("R7", "early edges not counted", rst_pull, 1'b0);
    mr2_clock();
    step(DELAY - 1);
    chk("R8", "edge before test delay end", rst_pull, 1'b0);
    step();
    chk("R8", "pull after test delay", rst_pull, 1'b1);
    step(SHORT + 1);
    chk("R8", "test pulse ended", rst_pull, 1'b0);
    idle(3);

    // R9: seven edges then release clears the count
    mr1_n = 1'b0;
    step(SETUP + 2);
    for (int k = 0; k < 7; k++) mr2_clock();
    mr1_n = 1'b1; step();
    mr1_n = 1'b0;
    step(SETUP + 2);
    for (int k = 0; k < 7; k++) mr2_clock();
    step(DELAY + 3);
    chk("R9", "aborted entry gives no pulse", rst_pull, 1'b0);
    mr2_clock();
    step(DELAY);
    chk("R8", "eighth fresh edge fires", rst_pull, 1'b1);
    step(SHORT + 1);
    idle(3);

    // R10: reset mid-hold and mid-pulse
    hold_sel = 3'd0;
    mr1_n = 1'b0; mr2_n = 1'b0;
    step(10);
    rst = 1'b1; step();
    rst = 1'b0;
    step(HALF - 1);
    chk("R10", "count cleared by reset", rst_pull, 1'b0);
    step();
    chk("R10", "full count after reset", rst_pull, 1'b1);
    step(2);
    rst = 1'b1; step();
    chk("R10", "pulse cut by reset", rst_pull, 1'b0);
    rst = 1'b0;
    idle(3);
    chk("R5", "idle released", rst_line_n, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule